// File: doc/BRIEF.md
# Host Bus Style Detector and Vector Port

This block sits between an 8-bit parallel host port and an internal register file. The host can use one of two bus styles. In the split style, the default, separate active-low read and write strobes are qualified by chip select. In the combined style, one line gives the transfer direction, chip select marks the transfer, and the block answers with an open-drain transfer acknowledge. The block decides which style the host uses from the first chip-select or write-line activity after reset. It then locks that choice until the next reset.

Host strobes are brought into the block clock domain through two-flop synchronizers. The block turns them into one-cycle read and write pulses for the register file, together with a captured address and write data. It also holds an 8-bit interrupt vector. During an interrupt-acknowledge cycle, and only when the interrupt-enable flag is set, the block drives the vector onto the data bus. Until software writes the vector, its value follows the locked style: 00h in the split style and 0Fh in the combined style. Register-file traffic uses plain one-cycle pulses with no back-pressure, because the host bus has no way to stall.

Top module: `host_mode_port`

## Requirements
- R1: After reset the block is in the split style (`mode_rw`=0), unlocked, with `host_ack_pull`=0, `host_dout_oe`=0 and no register pulses.
- R2: A falling edge of `host_wr_n` while `host_cs_n` is high, before the style is locked, selects the combined style. `mode_rw` and `mode_locked` rise 3 clocks after the input edge.
- R3: If a falling edge of `host_cs_n` arrives while the block is unlocked, it locks the split style. After that, a fall of `host_wr_n` with chip select high has no effect on `mode_rw`.
- R4: Once locked, the style does not change until reset. Reset always returns the block to the split style.
- R5: Split style write: a fall of `host_wr_n` while `host_cs_n` is low gives one `regf_wr` pulse 3 clocks later. The pulse carries the `host_addr` and `host_din` values held at that time.
- R6: Split style read: a fall of `host_rd_n` while `host_cs_n` is low gives one `regf_rd` pulse 3 clocks later. While both lines stay low, `host_dout_oe`=1 and `host_dout` equals `regf_rdata`.
- R7: Combined style: a fall of `host_cs_n` gives a write pulse if `host_wr_n` is low and a read pulse if it is high. During a read, the data bus is driven with `regf_rdata` while chip select stays low.
- R8: `host_ack_pull` is only ever 1 in the combined style. It rises 4 clocks after chip select falls, which is one clock after the access pulse. It falls 4 clocks after chip select rises.
- R9: The 8-bit vector is written by a register write to address 3. Until it is written, it reads 00h in the split style and 0Fh in the combined style.
- R10: With `host_iack_n` low and `irq_enable`=1, the bus is driven with the vector 3 clocks later. With `irq_enable`=0, the bus is not driven.
- R11: `host_dout_oe` is never 1 while a write is in progress (chip select low and write line low), even during an interrupt acknowledge.
- R12: The host keeps register-file pulses at least 3 clocks apart. This is 6 clocks at the two fastest clock settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_wr_n | input | 1 | Write strobe (split) or direction line, low = write (combined) |
| host_rd_n | input | 1 | Read strobe, split style only |
| host_iack_n | input | 1 | Interrupt acknowledge, active low |
| host_addr | input | 2 | Register select from the host |
| host_din | input | 8 | Data from the host |
| host_dout | output | 8 | Data to the host |
| host_dout_oe | output | 1 | Data bus output enable |
| host_ack_pull | output | 1 | 1 = pull the open-drain transfer acknowledge low |
| irq_enable | input | 1 | Interrupt-enable flag from the control register |
| regf_wr | output | 1 | One-cycle register write pulse |
| regf_rd | output | 1 | One-cycle register read pulse |
| regf_addr | output | 2 | Captured register address |
| regf_wdata | output | 8 | Captured write data |
| regf_rdata | input | 8 | Read data from the register file |
| mode_rw | output | 1 | 1 = combined read/write style |
| mode_locked | output | 1 | Sticky style-locked flag |

## Verification
Every result has a latency counted from a host input edge. Style flags, register pulses, and data-bus enables appear 3 clocks after the edge: two synchronizer flops plus one decode register. The acknowledge appears one clock after that, both when it rises and when it falls. The bench drives inputs on falling clock edges and waits exactly that number of falling edges before it samples. For R2 and R8 it also samples one edge early to show the output has not yet moved. A queue-based monitor compares every register pulse against the item the driver expected. Any pulse that arrives with nothing queued is reported as a failure, which covers accesses that should have been ignored.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  typedef enum logic {HB_SPLIT = 1'b0, HB_RW = 1'b1} hb_mode_e;

  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic rd_n;
    logic iack_n;
  } hb_pins_t;

  localparam int HB_NPINS = $bits(hb_pins_t);
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] fall
);
  logic [W-1:0] stage [STAGES];
  logic [W-1:0] prev;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[i] <= '1;
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else prev <= stage[STAGES-1];
  end

  assign q    = stage[STAGES-1];
  assign fall = prev & ~stage[STAGES-1];
endmodule

// File: rtl/hb_mode_detect.sv
module hb_mode_detect
  import hbm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_s,
  input  logic     cs_fall,
  input  logic     wr_fall,
  output hb_mode_e mode,
  output logic     locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= HB_SPLIT;
      locked <= 1'b0;
    end else if (!locked) begin
      if (wr_fall && cs_s) begin
        mode   <= HB_RW;
        locked <= 1'b1;
      end else if (cs_fall) begin
        locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/hb_strobe_decode.sv
module hb_strobe_decode
  import hbm_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hb_mode_e      mode,
  input  hb_pins_t      pin_s,
  input  hb_pins_t      pin_fall,
  input  logic          int_en,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic          wr_pulse,
  output logic          rd_pulse,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          rd_oe,
  output logic          vec_oe,
  output logic          ack_pull
);
  logic alt, sel, wr_ev, rd_ev, wr_busy, rd_busy, vec_busy, hold_q;

  always_comb begin
    alt      = (mode == HB_RW);
    sel      = ~pin_s.cs_n;
    wr_ev    = alt ? (pin_fall.cs_n & ~pin_s.wr_n) : (sel & pin_fall.wr_n);
    rd_ev    = alt ? (pin_fall.cs_n &  pin_s.wr_n) : (sel & pin_fall.rd_n);
    wr_busy  = sel & ~pin_s.wr_n;
    rd_busy  = alt ? (sel & pin_s.wr_n) : (sel & ~pin_s.rd_n);
    vec_busy = ~pin_s.iack_n & int_en & ~wr_busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse <= 1'b0;
      rd_pulse <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rd_oe    <= 1'b0;
      vec_oe   <= 1'b0;
      hold_q   <= 1'b0;
      ack_pull <= 1'b0;
    end else begin
      wr_pulse <= wr_ev;
      rd_pulse <= rd_ev;
      if (wr_ev || rd_ev) begin
        addr_q  <= addr_in;
        wdata_q <= data_in;
      end
      rd_oe    <= rd_busy & ~vec_busy;
      vec_oe   <= vec_busy;
      hold_q   <= alt & (sel | vec_busy);
      ack_pull <= hold_q & alt;
    end
  end
endmodule

// File: rtl/hb_vector_reg.sv
module hb_vector_reg
  import hbm_pkg::*;
#(
  parameter int          DW          = 8,
  parameter logic [DW-1:0] SPLIT_DFLT = '0,
  parameter logic [DW-1:0] RW_DFLT    = DW'(8'h0F)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hb_mode_e      mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] vector
);
  logic          written;
  logic [DW-1:0] value_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written <= 1'b0;
      value_q <= '0;
    end else if (wr_en) begin
      written <= 1'b1;
      value_q <= wdata;
    end
  end

  assign vector = written ? value_q : ((mode == HB_RW) ? RW_DFLT : SPLIT_DFLT);
endmodule

// File: rtl/host_mode_port.sv
module host_mode_port
  import hbm_pkg::*;
#(
  parameter int            ADDR_W   = 2,
  parameter int            DATA_W   = 8,
  parameter int            VEC_ADDR = 3,
  parameter logic [DATA_W-1:0] RW_VEC = DATA_W'(8'h0F)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_wr_n,
  input  logic              host_rd_n,
  input  logic              host_iack_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_din,
  output logic [DATA_W-1:0] host_dout,
  output logic              host_dout_oe,
  output logic              host_ack_pull,
  input  logic              irq_enable,
  output logic              regf_wr,
  output logic              regf_rd,
  output logic [ADDR_W-1:0] regf_addr,
  output logic [DATA_W-1:0] regf_wdata,
  input  logic [DATA_W-1:0] regf_rdata,
  output logic              mode_rw,
  output logic              mode_locked
);
  localparam logic [ADDR_W-1:0] VEC_SEL = ADDR_W'(VEC_ADDR);

  hb_pins_t    raw, pin_s, pin_fall;
  hb_mode_e    mode;
  logic        rd_oe, vec_oe;
  logic [DATA_W-1:0] vector;

  assign raw = '{cs_n: host_cs_n, wr_n: host_wr_n, rd_n: host_rd_n, iack_n: host_iack_n};

  hb_sync #(.W(HB_NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(pin_s), .fall(pin_fall)
  );

  hb_mode_detect u_mode (
    .clk(clk), .rst_n(rst_n), .cs_s(pin_s.cs_n), .cs_fall(pin_fall.cs_n),
    .wr_fall(pin_fall.wr_n), .mode(mode), .locked(mode_locked)
  );

  hb_strobe_decode #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pin_s(pin_s), .pin_fall(pin_fall),
    .int_en(irq_enable), .addr_in(host_addr), .data_in(host_din),
    .wr_pulse(regf_wr), .rd_pulse(regf_rd), .addr_q(regf_addr), .wdata_q(regf_wdata),
    .rd_oe(rd_oe), .vec_oe(vec_oe), .ack_pull(host_ack_pull)
  );

  hb_vector_reg #(.DW(DATA_W), .SPLIT_DFLT('0), .RW_DFLT(RW_VEC)) u_vec (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .wr_en(regf_wr && (regf_addr == VEC_SEL)), .wdata(regf_wdata), .vector(vector)
  );

  assign mode_rw      = (mode == HB_RW);
  assign host_dout_oe = rd_oe | vec_oe;
  assign host_dout    = vec_oe ? vector : (rd_oe ? regf_rdata : '0);
endmodule

// File: rtl/host_mode_port_chk.sv
module host_mode_port_chk #(
  parameter int MIN_GAP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic host_cs_n,
  input logic host_wr_n,
  input logic host_dout_oe,
  input logic host_ack_pull,
  input logic regf_wr,
  input logic regf_rd,
  input logic mode_rw,
  input logic mode_locked
);
  localparam int CW = $clog2(MIN_GAP + 1) + 1;
  logic [CW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= CW'(MIN_GAP);
    else if (regf_wr || regf_rd) gap <= '0;
    else if (gap < CW'(MIN_GAP)) gap <= gap + 1'b1;
  end

  assert_style_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rw |=> mode_rw);
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_locked |=> mode_locked);
  assert_rw_implies_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rw |-> mode_locked);
  assert_ack_only_rw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack_pull |-> mode_rw);
  assert_pulse_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({regf_wr, regf_rd}));
  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    regf_wr |=> !regf_wr);
  assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    regf_rd |=> !regf_rd);
  assert_no_drive_on_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    regf_wr |-> !host_dout_oe);
  assert_access_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (regf_wr || regf_rd) |-> (gap >= CW'(MIN_GAP - 1)));
endmodule

bind host_mode_port host_mode_port_chk #(.MIN_GAP(3)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_wr_n(host_wr_n),
  .host_dout_oe(host_dout_oe), .host_ack_pull(host_ack_pull),
  .regf_wr(regf_wr), .regf_rd(regf_rd), .mode_rw(mode_rw), .mode_locked(mode_locked)
);

// File: tb/host_mode_port_test.sv
module host_mode_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, iack_n = 1'b1, irq_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] din = '0, rdata = '0;
  logic [7:0] dout;
  logic oe, ack, rwr, rrd, mrw, mlock;
  logic [1:0] raddr;
  logic [7:0] rwdata;
  int tests = 0, fails = 0;

  typedef struct { bit is_wr; logic [1:0] a; logic [7:0] d; string tag; } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  host_mode_port uut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_wr_n(wr_n), .host_rd_n(rd_n),
    .host_iack_n(iack_n), .host_addr(addr), .host_din(din), .host_dout(dout),
    .host_dout_oe(oe), .host_ack_pull(ack), .irq_enable(irq_en), .regf_wr(rwr),
    .regf_rd(rrd), .regf_addr(raddr), .regf_wdata(rwdata), .regf_rdata(rdata),
    .mode_rw(mrw), .mode_locked(mlock)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every register pulse must match the next expected item
  always @(negedge clk) begin
    if (rst_n && (rwr || rrd)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected pulse", {rwr, rrd}, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(rwr == it.is_wr, it.tag, rwr, it.is_wr);
        check(raddr == it.a, it.tag, raddr, it.a);
        if (it.is_wr) check(rwdata == it.d, it.tag, rwdata, it.d);
      end
    end
  end

  task automatic do_reset;
    cs_n = 1; wr_n = 1; rd_n = 1; iack_n = 1; irq_en = 0;
    rst_n = 0; cyc(3); rst_n = 1; cyc(2);
  endtask

  task automatic split_write(input logic [1:0] a, input logic [7:0] d);
    exp_q.push_back('{1'b1, a, d, "R5"});
    addr = a; din = d; cs_n = 0; cyc(4);
    wr_n = 0; cyc(3);
    check(oe == 0, "R11 split write", oe, 0);
    cyc(1); wr_n = 1; cyc(4); cs_n = 1; cyc(6);
  endtask

  task automatic split_read(input logic [1:0] a, input logic [7:0] d);
    exp_q.push_back('{1'b0, a, 8'h00, "R6"});
    addr = a; rdata = d; cs_n = 0; cyc(4);
    rd_n = 0; cyc(4);
    check(oe == 1 && dout == d, "R6 read drive", {oe, dout}, {1'b1, d});
    rd_n = 1; cyc(4);
    check(oe == 0, "R6 release", oe, 0);
    cs_n = 1; cyc(6);
  endtask

  task automatic alt_write(input logic [1:0] a, input logic [7:0] d);
    wr_n = 0; cyc(4);
    exp_q.push_back('{1'b1, a, d, "R7"});
    addr = a; din = d; cs_n = 0; cyc(3);
    check(ack == 0, "R8 ack early", ack, 0);
    cyc(1);
    check(ack == 1, "R8 ack on", ack, 1);
    cyc(3); cs_n = 1; cyc(3);
    check(ack == 1, "R8 ack hold", ack, 1);
    cyc(1);
    check(ack == 0, "R8 ack off", ack, 0);
    wr_n = 1; cyc(4);
  endtask

  task automatic alt_read(input logic [1:0] a, input logic [7:0] d);
    wr_n = 1; rdata = d;
    exp_q.push_back('{1'b0, a, 8'h00, "R7"});
    addr = a; cs_n = 0; cyc(4);
    check(oe == 1 && dout == d, "R7 read drive", {oe, dout}, {1'b1, d});
    cs_n = 1; cyc(6);
  endtask

  task automatic vec_check(input bit en, input bit exp_oe, input logic [7:0] v, input string tag);
    irq_en = en; iack_n = 0; cyc(4);
    check(oe == exp_oe, tag, oe, exp_oe);
    if (exp_oe) check(dout == v, tag, dout, v);
    iack_n = 1; cyc(5); irq_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset;
    // R1 reset state
    check(mrw == 0 && mlock == 0, "R1 style", {mrw, mlock}, 0);
    check(ack == 0 && oe == 0, "R1 outputs", {ack, oe}, 0);
    vec_check(1, 1, 8'h00, "R9 split default");
    check(mlock == 0, "R3 iack does not lock", mlock, 0);
    split_write(2'd1, 8'hA5);
    check(mlock == 1 && mrw == 0, "R3 split locked", {mlock, mrw}, 2'b10);
    wr_n = 0; cyc(4);
    check(mrw == 0, "R3 late wr fall ignored", mrw, 0);
    wr_n = 1; cyc(4);
    split_read(2'd2, 8'h3C);
    split_write(2'd3, 8'h77);
    vec_check(1, 1, 8'h77, "R9 written vector");
    vec_check(0, 0, 8'h00, "R10 irq disabled");
    do_reset;
    check(mrw == 0 && mlock == 0, "R4 reset to split", {mrw, mlock}, 0);
    vec_check(1, 1, 8'h00, "R4 vector back to 00");
    // R2 combined style detection timing
    wr_n = 0; cyc(2);
    check(mrw == 0, "R2 not yet", mrw, 0);
    cyc(1);
    check(mrw == 1 && mlock == 1, "R2 combined locked", {mrw, mlock}, 2'b11);
    wr_n = 1; cyc(4);
    vec_check(1, 1, 8'h0F, "R9 combined default");
    alt_write(2'd0, 8'h11);
    alt_write(2'd3, 8'h5A);
    vec_check(1, 1, 8'h5A, "R10 vector driven");
    alt_read(2'd1, 8'hC3);
    // R11: write during interrupt acknowledge must not drive the bus
    wr_n = 0; cyc(4);
    exp_q.push_back('{1'b1, 2'd2, 8'h99, "R11"});
    addr = 2'd2; din = 8'h99; irq_en = 1; iack_n = 0; cs_n = 0; cyc(4);
    check(oe == 0, "R11 no drive during write", oe, 0);
    cs_n = 1; iack_n = 1; irq_en = 0; cyc(4); wr_n = 1; cyc(6);
    check(mrw == 1 && mlock == 1, "R4 still combined", {mrw, mlock}, 2'b11);
    do_reset;
    check(mrw == 0 && ack == 0, "R4 reset from combined", {mrw, ack}, 0);
    cyc(4);
    check(exp_q.size() == 0, "R5 all pulses seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule